// File: doc/BRIEF.md
# Iterative Vectoring CORDIC Rectangular-to-Polar Converter

The block turns one complex sample (an in-phase and a quadrature value in two's complement) into a magnitude and a phase angle. It uses one shift-and-add micro-rotation per clock. A strobe on `in_valid` loads a sample from one of two source buses. `wide_sel` picks either an 18-bit pair or a 26-bit pair. Both are read as fractions of full scale, so the same vector gives the same result on either bus. If the vector lies in the left half-plane, it is first turned through half a turn. Sixteen micro-rotations then drive its quadrature part toward zero while a binary-angle accumulator sums the arctangent steps.

A conversion at full precision takes 17 clock edges from the loading edge to the result capture. The captured magnitude and phase stay in holding registers until the next capture. A one-cycle `out_valid` pulse marks each capture. The input never stalls and has no ready signal. A strobe that arrives while a conversion is still running captures whatever that conversion holds at that moment, with the same pulse, and the new sample starts at once. A faster sample rate therefore costs precision but never drops a sample. The output has no back-pressure: a consumer must take the held values on or after the pulse, before the next pulse replaces them.

Top module: `rect2polar_cordic`

## Requirements
- R1: A synchronous reset clears the conversion in progress, drives `out_valid` low and sets `mag`, `phase` and `phase_disc` to zero.
- R2: `wide_sel`=0 converts the 18-bit pair and `wide_sel`=1 converts the 26-bit pair. The bus that is not selected has no effect. The MSB of each bus weighs -1.0 of full scale, so an 18-bit value v and the 26-bit value v·256 give identical results.
- R3: If no new strobe intervenes, `out_valid` is high for exactly the one cycle that follows the 17th rising edge after the loading edge. `out_valid` is never high at any other time except as R4 describes.
- R4: A strobe that arrives n edges after the previous load (1 ≤ n ≤ 17) captures the result of n-1 micro-rotations, with `out_valid` high in the next cycle, and restarts on the new sample.
- R5: A strobe that arrives while no conversion is running produces no `out_valid` in the next cycle.
- R6: `phase` is a 16-bit binary angle. 0x0000 is 0°, 0x4000 is 90°, 0x8000 is 180° and 0xC000 is 270°. Bit 15 weighs 180° and each lower bit weighs half the one above it. At full precision the value lies within ±3 LSB of atan2(Q, I), read modulo one turn.
- R7: `phase_disc` is the 18-bit angle. Its upper 16 bits always equal `phase`.
- R8: `mag` is unsigned, with bit 13 weighing 1.0 of full scale and bit 0 weighing 2^-13. At full precision it equals sqrt(I²+Q²)·G within ±3 LSB, where G = ∏ sqrt(1+2^-2k) for k = 0..15 (about 1.64676). Bit 15 is always 0.
- R9: Between `out_valid` pulses, `mag`, `phase` and `phase_disc` do not change.
- R10: A result that a strobe cuts short after m micro-rotations has a phase error no greater than atan(2^-(m-1)) plus 3 LSB (90° plus 3 LSB when m=0). Its magnitude carries a gain of ∏ sqrt(1+2^-2k) for k < m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; always accepted |
| wide_sel | input | 1 | 0: 18-bit source, 1: 26-bit source |
| in_i_nar | input | 18 | In-phase value, 18-bit source |
| in_q_nar | input | 18 | Quadrature value, 18-bit source |
| in_i_wide | input | 26 | In-phase value, 26-bit source |
| in_q_wide | input | 26 | Quadrature value, 26-bit source |
| out_valid | output | 1 | One-cycle pulse per captured result |
| mag | output | 16 | Held magnitude including CORDIC gain |
| phase | output | 16 | Held phase, binary angle, truncated |
| phase_disc | output | 18 | Held phase at full internal width |

## Verification
The four axis vectors show whether the half-turn pre-rotation and the sign convention of each micro-rotation land on the right quarter. Diagonals in every quadrant and the most negative corner show whether the arctangent table and the guard bits are correct. Vectors on the wide bus, and one vector sent on both buses while the other bus carries junk, test the selection and the alignment of the two buses. Strobes repeated after 0, 3, 8, 15 and 16 idle cycles, a strobe while idle, and a reset in the middle of a conversion test the capture timing and the tolerance on partial results.

// File: rtl/r2p_pkg.sv
package r2p_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Arctangent of 2^-k as a binary angle of pw bits (full word = one turn), rounded.
  function automatic int atan_code(input int k, input int pw);
    real turns;
    turns = $atan(2.0 ** (-k)) / TWO_PI;
    return $rtoi(turns * (2.0 ** pw) + 0.5);
  endfunction

endpackage

// File: rtl/r2p_prerotate.sv
module r2p_prerotate #(
  parameter int NARROW_W = 18,
  parameter int WIDE_W   = 26,
  parameter int DW       = 28,
  parameter int PW       = 18
) (
  input  logic                 wide_sel,
  input  logic [NARROW_W-1:0]  i_nar,
  input  logic [NARROW_W-1:0]  q_nar,
  input  logic [WIDE_W-1:0]    i_wide,
  input  logic [WIDE_W-1:0]    q_wide,
  output logic signed [DW-1:0] x0,
  output logic signed [DW-1:0] y0,
  output logic [PW-1:0]        z0
);
  localparam int PAD = WIDE_W - NARROW_W;
  localparam int EXT = DW - WIDE_W;

  logic [WIDE_W-1:0] i_al, q_al;
  logic signed [DW-1:0] xa, ya;
  logic flip;

  // Left-justify the narrow source so both sources share one full-scale point.
  generate
    if (PAD > 0) begin : g_pad
      assign i_al = wide_sel ? i_wide : {i_nar, {PAD{1'b0}}};
      assign q_al = wide_sel ? q_wide : {q_nar, {PAD{1'b0}}};
    end else begin : g_same
      assign i_al = wide_sel ? i_wide : i_nar;
      assign q_al = wide_sel ? q_wide : q_nar;
    end
  endgenerate

  assign xa   = {{EXT{i_al[WIDE_W-1]}}, i_al};
  assign ya   = {{EXT{q_al[WIDE_W-1]}}, q_al};
  assign flip = i_al[WIDE_W-1];

  // Half-turn rotation into the right half-plane.
  always_comb begin
    if (flip) begin
      x0 = -xa;
      y0 = -ya;
      z0 = {1'b1, {(PW-1){1'b0}}};
    end else begin
      x0 = xa;
      y0 = ya;
      z0 = '0;
    end
  end
endmodule

// File: rtl/r2p_atan_rom.sv
module r2p_atan_rom #(
  parameter int ITERS = 16,
  parameter int PW    = 18,
  parameter int CW    = 5
) (
  input  logic [CW-1:0] idx,
  output logic [PW-1:0] angle
);
  logic [PW-1:0] tbl [ITERS];

  generate
    for (genvar g = 0; g < ITERS; g++) begin : g_ent
      localparam int CODE = r2p_pkg::atan_code(g, PW);
      assign tbl[g] = PW'(CODE);
    end
  endgenerate

  always_comb begin
    angle = '0;
    for (int j = 0; j < ITERS; j++) begin
      if (idx == CW'(j)) angle = tbl[j];
    end
  end
endmodule

// File: rtl/r2p_micro_rot.sv
module r2p_micro_rot #(
  parameter int DW = 28,
  parameter int PW = 18,
  parameter int CW = 5
) (
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic [PW-1:0]        z_i,
  input  logic [CW-1:0]        k_i,
  input  logic [PW-1:0]        ang_i,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic [PW-1:0]        z_o
);
  logic signed [DW-1:0] xs, ys;

  assign xs = x_i >>> k_i;
  assign ys = y_i >>> k_i;

  // Non-negative Q: turn clockwise and credit the angle; otherwise the reverse.
  always_comb begin
    if (!y_i[DW-1]) begin
      x_o = x_i + ys;
      y_o = y_i - xs;
      z_o = z_i + ang_i;
    end else begin
      x_o = x_i - ys;
      y_o = y_i + xs;
      z_o = z_i - ang_i;
    end
  end
endmodule

// File: rtl/rect2polar_cordic.sv
module rect2polar_cordic #(
  parameter int NARROW_W = 18,
  parameter int WIDE_W   = 26,
  parameter int GUARD    = 2,
  parameter int PH_W     = 18,
  parameter int PHO_W    = 16,
  parameter int MAG_W    = 16,
  parameter int CYCLES   = 17
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                wide_sel,
  input  logic [NARROW_W-1:0] in_i_nar,
  input  logic [NARROW_W-1:0] in_q_nar,
  input  logic [WIDE_W-1:0]   in_i_wide,
  input  logic [WIDE_W-1:0]   in_q_wide,
  output logic                out_valid,
  output logic [MAG_W-1:0]    mag,
  output logic [PHO_W-1:0]    phase,
  output logic [PH_W-1:0]     phase_disc
);
  localparam int ITERS    = CYCLES - 1;
  localparam int DW       = WIDE_W + GUARD;
  localparam int CW       = $clog2(CYCLES);
  localparam int MAG_FRAC = MAG_W - 3;
  localparam int MAG_LSB  = WIDE_W - 1 - MAG_FRAC;

  logic signed [DW-1:0] x_q, y_q, x0, y0, x1, y1;
  logic [PH_W-1:0]      z_q, z0, z1, ang;
  logic [CW-1:0]        cnt;
  logic                 busy;
  logic [MAG_W-1:0]     mag_q;
  logic [PH_W-1:0]      ph_q;
  logic                 vld_q;

  r2p_prerotate #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .DW(DW), .PW(PH_W)) u_pre (
    .wide_sel (wide_sel),
    .i_nar    (in_i_nar),
    .q_nar    (in_q_nar),
    .i_wide   (in_i_wide),
    .q_wide   (in_q_wide),
    .x0       (x0),
    .y0       (y0),
    .z0       (z0)
  );

  r2p_atan_rom #(.ITERS(ITERS), .PW(PH_W), .CW(CW)) u_rom (
    .idx   (cnt),
    .angle (ang)
  );

  r2p_micro_rot #(.DW(DW), .PW(PH_W), .CW(CW)) u_rot (
    .x_i   (x_q),
    .y_i   (y_q),
    .z_i   (z_q),
    .k_i   (cnt),
    .ang_i (ang),
    .x_o   (x1),
    .y_o   (y1),
    .z_o   (z1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      vld_q <= 1'b0;
      mag_q <= '0;
      ph_q  <= '0;
      x_q   <= '0;
      y_q   <= '0;
      z_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (in_valid) begin
        if (busy) begin
          mag_q <= x_q[MAG_LSB +: MAG_W];
          ph_q  <= z_q;
          vld_q <= 1'b1;
        end
        x_q  <= x0;
        y_q  <= y0;
        z_q  <= z0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == CW'(ITERS)) begin
          mag_q <= x_q[MAG_LSB +: MAG_W];
          ph_q  <= z_q;
          vld_q <= 1'b1;
          busy  <= 1'b0;
        end else begin
          x_q <= x1;
          y_q <= y1;
          z_q <= z1;
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign out_valid  = vld_q;
  assign mag        = mag_q;
  assign phase_disc = ph_q;
  assign phase      = ph_q[PH_W-1 -: PHO_W];
endmodule

// File: rtl/r2p_checker.sv
module r2p_checker #(
  parameter int CYCLES = 17,
  parameter int MAG_W  = 16,
  parameter int PH_W   = 18
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [MAG_W-1:0] mag,
  input logic [PH_W-1:0]  phase_disc
);
  localparam int AW = $clog2(CYCLES + 1);

  // Edges since the last load; zero when no conversion runs.
  logic [AW-1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (in_valid) age <= AW'(1);
    else if (age == AW'(CYCLES)) age <= '0;
    else if (age != '0) age <= age + 1'b1;
  end

  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> !out_valid);
  // R3
  full_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (age == AW'(CYCLES) && !in_valid) |=> out_valid);
  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(age == AW'(CYCLES) || (in_valid && age != '0)));
  // R4
  preempt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && age != '0) |=> out_valid);
  // R5
  idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && age == '0) |=> !out_valid);
  // R8
  mag_msb_chk: assert property (@(posedge clk) disable iff (rst) out_valid |-> !mag[MAG_W-1]);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(mag) && $stable(phase_disc)));
endmodule

bind rect2polar_cordic r2p_checker #(.CYCLES(CYCLES), .MAG_W(MAG_W), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .mag        (mag),
  .phase_disc (phase_disc)
);

// File: tb/rect2polar_cordic_tb.sv
module rect2polar_cordic_tb;
  localparam real PI2 = 6.283185307179586;
  localparam int  FULL = 17;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1, in_valid = 1'b0, wide_sel = 1'b0;
  logic [17:0] in_i_nar = '0, in_q_nar = '0;
  logic [25:0] in_i_wide = '0, in_q_wide = '0;
  logic        out_valid;
  logic [15:0] mag, phase;
  logic [17:0] phase_disc;

  rect2polar_cordic u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .wide_sel(wide_sel),
    .in_i_nar(in_i_nar), .in_q_nar(in_q_nar), .in_i_wide(in_i_wide), .in_q_wide(in_q_wide),
    .out_valid(out_valid), .mag(mag), .phase(phase), .phase_disc(phase_disc)
  );

  int checks = 0, fails = 0;
  int age = 0;
  real cur_i = 0.0, cur_q = 0.0;
  logic [15:0] last_mag = '0, last_ph = '0;
  logic [17:0] last_disc = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real gain(input int n);
    real g = 1.0;
    for (int k = 0; k < n; k++) g = g * $sqrt(1.0 + 2.0 ** (-2 * k));
    return g;
  endfunction

  task automatic check_result(input int n, input real fi, input real fq);
    real r, em, resid, tol_m, ep, d, tol_p;
    string tag;
    tag   = (n == FULL - 1) ? "R8" : "R10";
    r     = $sqrt(fi * fi + fq * fq);
    em    = gain(n) * r * 8192.0;
    resid = (n == 0) ? PI2 / 4.0 : $atan(2.0 ** (-(n - 1)));
    tol_m = 3.0 + em * (1.0 - $cos(resid));
    chk((mag - em <= tol_m) && (em - mag <= tol_m), tag, "magnitude", mag, $rtoi(em));
    chk(mag[15] == 1'b0, "R8", "magnitude msb", mag[15], 0);
    chk(phase_disc[17:2] == phase, "R7", "disc upper bits", phase_disc[17:2], phase);
    if (r > 1.0e-6) begin
      ep = $atan2(fq, fi) / PI2 * 65536.0;
      if (ep < 0.0) ep = ep + 65536.0;
      d = phase - ep;
      if (d >= 32768.0) d = d - 65536.0;
      if (d < -32768.0) d = d + 65536.0;
      tol_p = 3.0 + resid / PI2 * 65536.0;
      if (n == FULL - 1) tol_p = 3.0;
      chk((d <= tol_p) && (d >= -tol_p), (n == FULL - 1) ? "R6" : "R10", "phase", phase, $rtoi(ep));
    end
  endtask

  // One clock: apply inputs, advance the reference model across the edge, compare.
  task automatic step(input bit v, input bit wide, input longint iv, input longint qv);
    bit exp_v;
    int n;
    real pi_, pq_;
    string tag;
    in_valid = v;
    wide_sel = wide;
    if (wide) begin
      in_i_wide = iv[25:0]; in_q_wide = qv[25:0];
      in_i_nar  = 18'h2A5A5; in_q_nar = 18'h15A5A;
    end else begin
      in_i_nar  = iv[17:0]; in_q_nar = qv[17:0];
      in_i_wide = 26'h2A5_A5A5; in_q_wide = 26'h15A_5A5A;
    end
    @(posedge clk);
    #1;
    exp_v = 0; n = 0; pi_ = cur_i; pq_ = cur_q; tag = "R3";
    if (v) begin
      if (age > 0) begin exp_v = 1; n = age - 1; tag = "R4"; end
      else tag = "R5";
      age = 1;
      cur_i = real'(iv) / (wide ? 33554432.0 : 131072.0);
      cur_q = real'(qv) / (wide ? 33554432.0 : 131072.0);
    end else if (age == FULL) begin
      exp_v = 1; n = FULL - 1; age = 0;
    end else if (age > 0) age++;
    chk(out_valid == exp_v, tag, "out_valid", out_valid, exp_v);
    if (exp_v && out_valid) check_result(n, pi_, pq_);
    else if (!out_valid)
      chk(mag == last_mag && phase == last_ph && phase_disc == last_disc, "R9", "hold",
          {mag, phase}, {last_mag, last_ph});
    last_mag = mag; last_ph = phase; last_disc = phase_disc;
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step(0, 0, 0, 0);
  endtask

  task automatic convert(input bit wide, input longint iv, input longint qv);
    step(1, wide, iv, qv);
    idle(FULL);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    age = 0;
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(mag == 0 && phase == 0 && phase_disc == 0, "R1", "outputs after reset", {mag, phase}, 0);
    last_mag = mag; last_ph = phase; last_disc = phase_disc;
  endtask

  initial begin
    logic [15:0] m_a, p_a;
    #1;
    do_reset();
    // axis vectors at half scale
    convert(0, 65536, 0);
    convert(0, 0, 65536);
    convert(0, -65536, 0);
    convert(0, 0, -65536);
    // diagonals in each quadrant and the extreme corners
    convert(0, 90000, 40000);
    convert(0, -70000, 100000);
    convert(0, -120000, -30000);
    convert(0, 50000, -110000);
    convert(0, -131072, -131072);
    convert(0, 131071, 131071);
    // wide source
    convert(1, 20000000, -9000000);
    convert(1, -33554432, 12345678);
    convert(1, 1000000, 30000000);
    // same vector on both sources (R2)
    convert(0, 65536, 32768);
    m_a = mag; p_a = phase;
    convert(1, 65536 * 256, 32768 * 256);
    chk(mag == m_a && phase == p_a, "R2", "narrow vs wide", {mag, phase}, {m_a, p_a});
    // zero vector
    convert(0, 0, 0);
    // early strobes: cut short after 0, 3, 8, 15 and 16 rotations
    step(1, 0, 100000, 60000);
    step(1, 0, -80000, 20000);
    idle(3);
    step(1, 1, -20000000, -15000000);
    idle(8);
    step(1, 0, 30000, -120000);
    idle(15);
    step(1, 0, 110000, 5000);
    idle(16);
    step(1, 0, -60000, -60000);
    idle(FULL + 2);
    // reset in mid conversion
    step(1, 0, 70000, 70000);
    idle(5);
    do_reset();
    idle(FULL + 3);
    done = 1;
  end

  initial begin
    wait (done);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule